// File: doc/BRIEF.md
# Multi-sector NAND page reader

This block pulls between one and four sectors out of a small-page NAND device into a local buffer. Each sector is made of 512 main bytes and then 16 spare bytes that hold the error-code information. An upstream sequencer has already issued the read command and the address cycles. After that, a single start request hands this block a byte length and two buffer base addresses: one for main data and one for spare data. Checking or correcting the error code is not part of this block.

The block works through the request one sector at a time. Before each sector it waits for the device ready/busy line. It then moves the sector's main bytes in 64-byte bursts, and after them the 16 spare bytes. Every byte is fetched with an active-low read strobe. The low time and high time of the strobe are set by parameters. The byte is captured when the strobe rises and goes straight out on a buffer write port. The main-data destination advances by 512 for each sector and the spare destination advances by 16. When the last spare byte of the final sector has been written, a one-cycle done pulse follows.

Top module: `nand_sector_reader`

## Requirements
- R1: Out of reset, `flash_re_n_o` is high, and `buf_we_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: A start with a length of 0, a length that is not a multiple of 512, or a length above 2048 raises `err_o` for exactly the one cycle after the start. In that case no strobe falls, no buffer write occurs and `busy_o` stays low.
- R3: A valid length L moves L/512 sectors. Each sector produces 512 writes with `buf_spare_o` low, then 16 writes with `buf_spare_o` high, so L/512 × 528 writes in all.
- R4: Before the first main byte of every sector, the block waits for `flash_rdy_i` to be high (high means ready). No strobe falls while the line is low at a sector boundary.
- R5: Main byte i of sector n is written to data base + 512·n + i. Spare byte j of sector n is written to spare base + 16·n + j. Both addresses wrap modulo 2^ADDR_W.
- R6: Each write carries the byte that `flash_data_i` held at the rising edge of the strobe. The write strobe is high in the cycle that starts at that edge, and bytes are written in the order they were read.
- R7: The strobe stays low for exactly RE_LOW_CYC cycles. Inside a burst, consecutive writes are RE_LOW_CYC + RE_HIGH_CYC + 1 cycles apart.
- R8: The 512 main bytes of a sector are moved as 8 bursts of 64 bytes. At each 64-byte boundary inside the main data, the write interval is one cycle longer than the in-burst interval.
- R9: `done_o` is high for exactly one cycle, namely the cycle right after the final spare write. `busy_o` is low in that same cycle.
- R10: A start request that arrives while `busy_o` is high is ignored. The transfer already running keeps its length and its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| len_i | input | LEN_W | Number of main bytes to read |
| data_base_i | input | ADDR_W | Buffer base address for main bytes |
| spare_base_i | input | ADDR_W | Buffer base address for spare bytes |
| flash_rdy_i | input | 1 | Device ready/busy line, high when ready |
| flash_data_i | input | DATA_W | Device data bus |
| flash_re_n_o | output | 1 | Active-low read strobe to the device |
| buf_we_o | output | 1 | Buffer write enable |
| buf_spare_o | output | 1 | High when the current write is a spare byte |
| buf_addr_o | output | ADDR_W | Buffer write address |
| buf_data_o | output | DATA_W | Buffer write data |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after the final spare write |
| err_o | output | 1 | One-cycle pulse when a length is rejected |

## Verification
The assertions assume three things about the inputs. The device holds `flash_data_i` stable around each strobe rise. The ready line is only pulled low between sectors, never in the middle of a sector's data. `start_i` is a single-cycle pulse. The stimulus respects all three. The flash model places a new byte on each falling strobe. The bench drops the ready line only just after the last spare write of a sector and holds it low for a fixed number of cycles. Each start is driven for one cycle, including the one that deliberately lands in the middle of a transfer.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
   typedef enum logic [2:0] {
      RD_IDLE,
      RD_WAIT,
      RD_DATA,
      RD_GAP,
      RD_SPARE
   } rd_state_e;
endpackage

// File: rtl/nsr_len_check.sv
module nsr_len_check #(
   parameter int LEN_W        = 12,
   parameter int SECTOR_BYTES = 512,
   parameter int MAX_SECTORS  = 4,
   parameter int SEC_W        = 3
) (
   input  logic [LEN_W-1:0] len_i,
   output logic             ok_o,
   output logic [SEC_W-1:0] sectors_o
);
   localparam int          SHIFT   = $clog2(SECTOR_BYTES);
   localparam int unsigned MAX_LEN = MAX_SECTORS * SECTOR_BYTES;

   generate
      if ((1 << SHIFT) != SECTOR_BYTES) begin : g_bad_sector
         $error("SECTOR_BYTES must be a power of two");
      end
      if (LEN_W <= SHIFT || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("LEN_W cannot express the largest request");
      end
   endgenerate

   always_comb begin
      ok_o      = (len_i != '0) && (len_i[SHIFT-1:0] == '0) && (32'(len_i) <= MAX_LEN);
      sectors_o = SEC_W'(len_i >> SHIFT);
   end
endmodule

// File: rtl/nsr_re_strobe.sv
module nsr_re_strobe #(
   parameter int DATA_W   = 8,
   parameter int LOW_CYC  = 2,
   parameter int HIGH_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   output logic              ready_o,
   output logic              re_n_o,
   output logic              cap_o,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int CNT_W = $clog2(LOW_CYC + HIGH_CYC + 1);
   localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(LOW_CYC - 1);
   localparam logic [CNT_W-1:0] END_AT  = CNT_W'(LOW_CYC + HIGH_CYC - 1);

   generate
      if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad_timing
         $error("strobe low and high times must be at least one cycle");
      end
   endgenerate

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         re_n_o   <= 1'b1;
         cap_o    <= 1'b0;
         data_o   <= '0;
      end else begin
         cap_o <= 1'b0;
         if (!active_q) begin
            if (req_i) begin
               active_q <= 1'b1;
               cnt_q    <= '0;
               re_n_o   <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == RISE_AT) begin
               re_n_o <= 1'b1;
               cap_o  <= 1'b1;
               data_o <= data_i;
            end
            if (cnt_q == END_AT) begin
               active_q <= 1'b0;
            end
         end
      end
   end

   assign ready_o = !active_q;

   // R7: a new byte is only requested once the previous strobe cycle has ended
   a_r7_req_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      req_i |-> !active_q);
   // R6: capture happens only while a strobe cycle is in progress
   a_r6_cap_in_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      cap_o |-> active_q && re_n_o);
endmodule

// File: rtl/nsr_addr_gen.sv
module nsr_addr_gen #(
   parameter int ADDR_W       = 16,
   parameter int SECTOR_BYTES = 512,
   parameter int SPARE_BYTES  = 16,
   parameter int IDX_W        = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] data_base_i,
   input  logic [ADDR_W-1:0] spare_base_i,
   input  logic              step_i,
   input  logic              spare_sel_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              last_data_o,
   output logic              last_spare_o
);
   localparam logic [IDX_W-1:0]  DATA_LAST  = IDX_W'(SECTOR_BYTES - 1);
   localparam logic [IDX_W-1:0]  SPARE_LAST = IDX_W'(SPARE_BYTES - 1);
   localparam logic [ADDR_W-1:0] DATA_STEP  = ADDR_W'(SECTOR_BYTES);
   localparam logic [ADDR_W-1:0] SPARE_STEP = ADDR_W'(SPARE_BYTES);

   generate
      if (SPARE_BYTES < 1 || SPARE_BYTES > SECTOR_BYTES) begin : g_bad_spare
         $error("spare area must be between 1 byte and one sector");
      end
   endgenerate

   logic [ADDR_W-1:0] dptr_q, sptr_q;
   logic [IDX_W-1:0]  idx_q;

   assign last_data_o  = !spare_sel_i && (idx_q == DATA_LAST);
   assign last_spare_o = spare_sel_i && (idx_q == SPARE_LAST);
   assign idx_o        = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dptr_q <= '0;
         sptr_q <= '0;
         idx_q  <= '0;
      end else if (load_i) begin
         dptr_q <= data_base_i;
         sptr_q <= spare_base_i;
         idx_q  <= '0;
      end else if (step_i) begin
         if (last_data_o) begin
            idx_q <= '0;
         end else if (last_spare_o) begin
            idx_q  <= '0;
            dptr_q <= dptr_q + DATA_STEP;
            sptr_q <= sptr_q + SPARE_STEP;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   always_comb begin
      if (spare_sel_i) addr_o = sptr_q + ADDR_W'(idx_q);
      else             addr_o = dptr_q + ADDR_W'(idx_q);
   end

   // R5: while the spare area is selected the offset never leaves it
   a_r5_spare_idx : assert property (@(posedge clk) disable iff (!rst_n)
      spare_sel_i |-> idx_q < IDX_W'(SPARE_BYTES));
endmodule

// File: rtl/nand_sector_reader.sv
module nand_sector_reader #(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 16,
   parameter int LEN_W        = 12,
   parameter int SECTOR_BYTES = 512,
   parameter int SPARE_BYTES  = 16,
   parameter int BURST_BYTES  = 64,
   parameter int MAX_SECTORS  = 4,
   parameter int RE_LOW_CYC   = 2,
   parameter int RE_HIGH_CYC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] data_base_i,
   input  logic [ADDR_W-1:0] spare_base_i,
   input  logic              flash_rdy_i,
   input  logic [DATA_W-1:0] flash_data_i,
   output logic              flash_re_n_o,
   output logic              buf_we_o,
   output logic              buf_spare_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   output logic [DATA_W-1:0] buf_data_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   import nsr_pkg::*;

   localparam int SEC_W   = $clog2(MAX_SECTORS + 1);
   localparam int IDX_W   = $clog2(SECTOR_BYTES);
   localparam int BURST_W = $clog2(BURST_BYTES);

   generate
      if (BURST_BYTES < 2 || (1 << BURST_W) != BURST_BYTES || BURST_BYTES > SECTOR_BYTES) begin : g_bad_burst
         $error("BURST_BYTES must be a power of two no larger than a sector");
      end
      if (MAX_SECTORS < 1) begin : g_bad_max
         $error("MAX_SECTORS must be at least one");
      end
   endgenerate

   rd_state_e        state_q;
   logic [SEC_W-1:0] sec_left_q;
   logic             done_q, err_q;

   logic             len_ok;
   logic [SEC_W-1:0] len_sectors;
   logic             stb_req, stb_ready, stb_cap;
   logic [IDX_W-1:0] idx;
   logic             last_data, last_spare, spare_sel, load, burst_end;

   nsr_len_check #(
      .LEN_W(LEN_W), .SECTOR_BYTES(SECTOR_BYTES),
      .MAX_SECTORS(MAX_SECTORS), .SEC_W(SEC_W)
   ) u_len (
      .len_i(len_i), .ok_o(len_ok), .sectors_o(len_sectors)
   );

   nsr_re_strobe #(
      .DATA_W(DATA_W), .LOW_CYC(RE_LOW_CYC), .HIGH_CYC(RE_HIGH_CYC)
   ) u_stb (
      .clk(clk), .rst_n(rst_n), .req_i(stb_req), .ready_o(stb_ready),
      .re_n_o(flash_re_n_o), .cap_o(stb_cap),
      .data_i(flash_data_i), .data_o(buf_data_o)
   );

   nsr_addr_gen #(
      .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES),
      .SPARE_BYTES(SPARE_BYTES), .IDX_W(IDX_W)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(load),
      .data_base_i(data_base_i), .spare_base_i(spare_base_i),
      .step_i(stb_cap), .spare_sel_i(spare_sel), .addr_o(buf_addr_o),
      .idx_o(idx), .last_data_o(last_data), .last_spare_o(last_spare)
   );

   assign spare_sel = (state_q == RD_SPARE);
   assign load      = (state_q == RD_IDLE) && start_i && len_ok;
   assign burst_end = &idx[BURST_W-1:0];
   assign stb_req   = ((state_q == RD_DATA) || (state_q == RD_SPARE)) && stb_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RD_IDLE;
         sec_left_q <= '0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            RD_IDLE: begin
               if (start_i) begin
                  if (len_ok) begin
                     state_q    <= RD_WAIT;
                     sec_left_q <= len_sectors;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            RD_WAIT: begin
               if (flash_rdy_i) state_q <= RD_DATA;
            end
            RD_DATA: begin
               if (stb_cap) begin
                  if (last_data)      state_q <= RD_SPARE;
                  else if (burst_end) state_q <= RD_GAP;
               end
            end
            RD_GAP: begin
               if (stb_ready) state_q <= RD_DATA;
            end
            RD_SPARE: begin
               if (stb_cap && last_spare) begin
                  if (sec_left_q == SEC_W'(1)) begin
                     state_q <= RD_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     sec_left_q <= sec_left_q - SEC_W'(1);
                     state_q    <= RD_WAIT;
                  end
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign buf_we_o    = stb_cap;
   assign buf_spare_o = spare_sel;
   assign busy_o      = (state_q != RD_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;

   // R3: buffer writes only happen inside an accepted transfer
   a_r3_write_in_xfer : assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> busy_o);
   // R4: no strobe starts while waiting on a busy device
   a_r4_ready_gate : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_WAIT && !flash_rdy_i) |=> flash_re_n_o);
   // R9: completion is a single-cycle pulse
   a_r9_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R2: a rejected request leaves the block idle and silent
   a_r2_err_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o && !buf_we_o && flash_re_n_o);
   // R7: the strobe is never low outside a transfer
   a_r7_strobe_busy : assert property (@(posedge clk) disable iff (!rst_n)
      !flash_re_n_o |-> busy_o);
endmodule

// File: tb/tb_nand_sector_reader.sv
module tb_nand_sector_reader;
   localparam int LOWC = 3;
   localparam int HIGHC = 2;
   localparam int PER = LOWC + HIGHC + 1;
   localparam int GAPC = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] len_i = '0;
   logic [15:0] data_base_i = '0;
   logic [15:0] spare_base_i = '0;
   logic        flash_rdy_i = 1'b1;
   logic [7:0]  flash_data_i = '0;
   logic        flash_re_n_o, buf_we_o, buf_spare_o, busy_o, done_o, err_o;
   logic [15:0] buf_addr_o;
   logic [7:0]  buf_data_o;

   nand_sector_reader #(
      .DATA_W(8), .ADDR_W(16), .LEN_W(12), .SECTOR_BYTES(512), .SPARE_BYTES(16),
      .BURST_BYTES(64), .MAX_SECTORS(4), .RE_LOW_CYC(LOWC), .RE_HIGH_CYC(HIGHC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .data_base_i(data_base_i), .spare_base_i(spare_base_i),
      .flash_rdy_i(flash_rdy_i), .flash_data_i(flash_data_i),
      .flash_re_n_o(flash_re_n_o), .buf_we_o(buf_we_o), .buf_spare_o(buf_spare_o),
      .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   always #10 clk = ~clk;

   int n_tests = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc++;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(int k);
      return 8'((k * 37 + (k >> 7)) ^ 8'h5A);
   endfunction

   // flash model: next byte appears on each falling strobe
   int fcnt = 0;
   always @(negedge flash_re_n_o) begin
      flash_data_i = pat(fcnt);
      fcnt++;
   end

   // monitor
   int mk, bad_addr, bad_data, bad_flag, bad_int, bad_burst, bad_low, low_run;
   int rdy_viol, done_cnt, bad_done_w, last_we_cyc, first_we_cyc, hold;
   int exp_db, exp_sb;
   bit gap_mode, done_prev;

   task automatic mon_clear(int db, int sb, bit gm);
      mk = 0; bad_addr = 0; bad_data = 0; bad_flag = 0; bad_int = 0; bad_burst = 0;
      bad_low = 0; low_run = 0; rdy_viol = 0; done_cnt = 0; bad_done_w = 0;
      last_we_cyc = 0; first_we_cyc = 0; fcnt = 0;
      exp_db = db; exp_sb = sb; gap_mode = gm;
   endtask

   always @(negedge clk) begin
      if (hold > 0) begin
         hold--;
         if (hold == 0) flash_rdy_i = 1'b1;
      end
      if (buf_we_o) begin
         automatic int s = mk / 528;
         automatic int r = mk % 528;
         automatic int ea = (r < 512) ? (exp_db + 512 * s + r) : (exp_sb + 16 * s + r - 512);
         ea = ea & 16'hFFFF;
         if (int'(buf_addr_o) != ea) bad_addr++;
         if (buf_data_o != pat(mk)) bad_data++;
         if (buf_spare_o != (r >= 512)) bad_flag++;
         if (mk == 0) first_we_cyc = cyc;
         if (r != 0) begin
            if (r < 512 && r % 64 == 0) begin
               if (cyc - last_we_cyc != PER + 1) bad_burst++;
            end else if (cyc - last_we_cyc != PER) bad_int++;
         end
         last_we_cyc = cyc;
         if (gap_mode && r == 527) begin
            flash_rdy_i = 1'b0;
            hold = GAPC;
         end
         mk++;
      end
      if (!flash_rdy_i && !flash_re_n_o) rdy_viol++;
      if (!flash_re_n_o) low_run++;
      else begin
         if (low_run != 0 && low_run != LOWC) bad_low++;
         low_run = 0;
      end
      if (done_o) begin
         done_cnt++;
         if (done_prev) bad_done_w++;
      end
      done_prev = done_o;
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 190000) begin
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic pulse_start(int len, int db, int sb);
      start_i = 1'b1; len_i = 12'(len); data_base_i = 16'(db); spare_base_i = 16'(sb);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic t_reset();
      check(flash_re_n_o == 1'b1, "R1", "re_n after reset", flash_re_n_o, 1);
      check(buf_we_o == 1'b0, "R1", "we after reset", buf_we_o, 0);
      check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
      check(done_o == 1'b0 && err_o == 1'b0, "R1", "done/err after reset", done_o | err_o, 0);
   endtask

   task automatic t_reject(int len);
      @(negedge clk);
      mon_clear(0, 0, 1'b0);
      pulse_start(len, 16'h1000, 16'h2000);
      check(err_o == 1'b1, "R2", $sformatf("err pulse len=%0d", len), err_o, 1);
      check(busy_o == 1'b0, "R2", "busy stays low", busy_o, 0);
      @(negedge clk);
      check(err_o == 1'b0, "R2", "err one cycle", err_o, 0);
      repeat (40) @(negedge clk);
      check(fcnt == 0 && mk == 0, "R2", "no strobe or write", fcnt + mk, 0);
   endtask

   task automatic xfer_checks(int len, int start_cyc, string tag);
      automatic int nsec = len / 512;
      automatic int dcyc;
      while (!done_o) @(negedge clk);
      dcyc = cyc;
      check(busy_o == 1'b0, "R9", {tag, " busy low at done"}, busy_o, 0);
      check(dcyc == last_we_cyc + 1, "R9", {tag, " done after last write"}, dcyc - last_we_cyc, 1);
      repeat (30) @(negedge clk);
      check(done_cnt == 1 && bad_done_w == 0, "R9", {tag, " done pulse count"}, done_cnt, 1);
      check(mk == nsec * 528, "R3", {tag, " write count"}, mk, nsec * 528);
      check(bad_flag == 0, "R3", {tag, " spare flag"}, bad_flag, 0);
      check(bad_addr == 0, "R5", {tag, " addresses"}, bad_addr, 0);
      check(bad_data == 0, "R6", {tag, " data"}, bad_data, 0);
      check(bad_low == 0, "R7", {tag, " strobe low width"}, bad_low, 0);
      check(bad_int == 0, "R7", {tag, " byte interval"}, bad_int, 0);
      check(bad_burst == 0, "R8", {tag, " burst boundary gap"}, bad_burst, 0);
      check(rdy_viol == 0, "R4", {tag, " strobe while not ready"}, rdy_viol, 0);
      if (gap_mode)
         check(first_we_cyc - start_cyc >= GAPC, "R4", {tag, " waited for ready"},
               first_we_cyc - start_cyc, GAPC);
   endtask

   task automatic t_xfer(int len, int db, int sb, bit gm, string tag);
      automatic int sc;
      @(negedge clk);
      mon_clear(db, sb, gm);
      if (gm) begin
         flash_rdy_i = 1'b0;
         hold = GAPC;
      end
      sc = cyc;
      pulse_start(len, db, sb);
      xfer_checks(len, sc, tag);
   endtask

   task automatic t_start_while_busy();
      automatic int sc;
      @(negedge clk);
      mon_clear(16'h0400, 16'h3000, 1'b0);
      sc = cyc;
      pulse_start(1024, 16'h0400, 16'h3000);
      repeat (200) @(negedge clk);
      pulse_start(512, 16'h7000, 16'h7F00);   // R10: must be ignored
      xfer_checks(1024, sc, "R10 restart");
   endtask

   initial begin
      hold = 0;
      mon_clear(0, 0, 1'b0);
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reject(0);
      t_reject(100);
      t_reject(513);
      t_reject(2560);
      t_xfer(512, 16'h0100, 16'h8000, 1'b0, "one sector");
      t_xfer(2048, 16'h2000, 16'h9000, 1'b1, "four sectors gated");
      t_xfer(2048, 16'hFE00, 16'hFFE0, 1'b0, "wrap");
      t_xfer(1536, 16'h4000, 16'hA010, 1'b1, "three sectors");
      t_xfer(1024, 16'h0000, 16'h0000, 1'b0, "two sectors");
      t_start_while_busy();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule